// File: doc/BRIEF.md
# Event-Sensing Parallel I/O Ports

This block provides a bank of bidirectional digital lines grouped into byte-wide ports. A host reaches it through a simple byte register interface: one address bus, a write strobe with data, and a read strobe that returns data one cycle later. Every line has an output latch and a direction bit. A line can be left as an input, or it can be driven as an output. When a port is read, the host sees the synchronized pin level, so a line that is driving shows the level actually present on the pin.

Each port has a write-protect mask. Bits set in the mask keep their output latch value when the host writes that port's data. The lower ports, three by default, also watch their lines for changes. Each watched line has a polarity bit that chooses a rising or a falling transition. A detected transition sets a sticky pending bit, which stays set until the host clears it by writing a 1 to that bit. Each pending bit also has an enable bit. The enabled pending bits are ORed into a single interrupt line.

Top module: `evtio_ports`

## Requirements
- R1: After a synchronous reset, every output latch, direction bit, mask bit, polarity bit, enable bit and pending bit is 0, so pad_out, pad_oe and irq are all 0.
- R2: Writing address p (0..5) loads the output latch of port p, which drives pad_out[8p+7:8p]. Writing address 6+p loads the direction bits of port p, which drive pad_oe[8p+7:8p], with 1 meaning output.
- R3: The write-protect mask of port p sits at address 12+p. On a data write to port p, a bit whose mask bit is 1 keeps its old latch value and a bit whose mask bit is 0 takes the written value.
- R4: A read of address p (0..5) returns the pin levels of port p after a two-flop synchronizer, including lines configured as outputs. rd_data and rd_valid are updated at the clock edge that samples rd_en. A pin change made just before edge A becomes visible to a read that is sampled at edge C, two edges later.
- R5: For event port e (0..2), polarity bit 0 at address 18+e makes a 0-to-1 transition of the synchronized line set the pending bit. The pending bits are read at address 24+e.
- R6: Polarity bit 1 makes a 1-to-0 transition set the pending bit. The opposite transition leaves the pending bit unchanged.
- R7: A pending bit stays set until the host writes a 1 to it at address 24+e. Writing a 0 to a pending bit leaves it set.
- R8: If a transition is detected in the same cycle that its pending bit is cleared, the pending bit ends up set.
- R9: irq is 1 exactly when some pending bit has its enable bit set, one cycle after that condition arises. The enable bits are at address 21+e, with 1 meaning enabled. Pending bits whose enable bit is 0 do not raise irq.
- R10: Transitions on ports 3..5 never set any pending bit and never raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the read sampled at the previous edge |
| pad_in | input | 48 | Pin levels, asynchronous |
| pad_out | output | 48 | Output latch values |
| pad_oe | output | 48 | Per-line output enable |
| irq | output | 1 | Shared event interrupt |

## Verification
The bench goes after the following corner cases:
- A clear that lands in the same cycle as a new transition. A design that gives priority to the clear would lose that event.
- A masked data write. A design that ignored the mask would overwrite the protected bits.
- Transitions of the wrong polarity. A design that reacted to either edge would latch them.
- Read latency through the synchronizer, which is checked by reading on three consecutive edges.
- Activity on the upper ports. A design that tracked events on every port would latch that activity.
- A pending bit with its enable cleared. A design that ORed all pending bits into the interrupt would raise irq for it.

// File: rtl/evtio_pkg.sv
package evtio_pkg;
  typedef enum logic [2:0] {
    GRP_DATA,
    GRP_DIR,
    GRP_MASK,
    GRP_POL,
    GRP_EN,
    GRP_PEND,
    GRP_NONE
  } reg_grp_e;
endpackage

// File: rtl/evtio_sync.sv
module evtio_sync #(
  parameter int N = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q;
  logic [N-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/evtio_decode.sv
module evtio_decode
  import evtio_pkg::*;
#(
  parameter int NPORTS = 6,
  parameter int NEVT   = 3,
  parameter int AW     = 5,
  parameter int IW     = 3
) (
  input  logic [AW-1:0] addr,
  output reg_grp_e      grp,
  output logic [IW-1:0] idx
);
  localparam int DIR_BASE  = NPORTS;
  localparam int MASK_BASE = 2 * NPORTS;
  localparam int POL_BASE  = 3 * NPORTS;
  localparam int EN_BASE   = POL_BASE + NEVT;
  localparam int PEND_BASE = EN_BASE + NEVT;
  localparam int END_ADDR  = PEND_BASE + NEVT;

  always_comb begin
    int a;
    a   = int'(addr);
    grp = GRP_NONE;
    idx = '0;
    if (a < DIR_BASE) begin
      grp = GRP_DATA;
      idx = IW'(a);
    end else if (a < MASK_BASE) begin
      grp = GRP_DIR;
      idx = IW'(a - DIR_BASE);
    end else if (a < POL_BASE) begin
      grp = GRP_MASK;
      idx = IW'(a - MASK_BASE);
    end else if (a < EN_BASE) begin
      grp = GRP_POL;
      idx = IW'(a - POL_BASE);
    end else if (a < PEND_BASE) begin
      grp = GRP_EN;
      idx = IW'(a - EN_BASE);
    end else if (a < END_ADDR) begin
      grp = GRP_PEND;
      idx = IW'(a - PEND_BASE);
    end
  end
endmodule

// File: rtl/evtio_capture.sv
module evtio_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] evt;

  // polarity 0: rising, polarity 1: falling
  assign evt = (~prev_q & lvl & ~pol) | (prev_q & ~lvl & pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      pend_q <= (pend_q & ~clr) | evt;
    end
  end

  assign pend = pend_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
      evt[b] |=> pend_q[b]);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (pend_q[b] && !clr[b]) |=> pend_q[b]);
    assert_cleared_R7: assert property (@(posedge clk) disable iff (rst)
      (clr[b] && !evt[b]) |=> !pend_q[b]);
  end
endmodule

// File: rtl/evtio_ports.sv
module evtio_ports
  import evtio_pkg::*;
#(
  parameter int NPORTS = 6,
  parameter int NEVT   = 3,
  parameter int W      = 8,
  parameter int AW     = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr,
  input  logic                wr_en,
  input  logic [W-1:0]        wr_data,
  input  logic                rd_en,
  output logic [W-1:0]        rd_data,
  output logic                rd_valid,
  input  logic [NPORTS*W-1:0] pad_in,
  output logic [NPORTS*W-1:0] pad_out,
  output logic [NPORTS*W-1:0] pad_oe,
  output logic                irq
);
  localparam int NL  = NPORTS * W;
  localparam int NE  = NEVT * W;
  localparam int IW  = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int EIW = (NEVT > 1) ? $clog2(NEVT) : 1;

  reg_grp_e      grp;
  logic [IW-1:0] idx;
  logic [NL-1:0] pin_s;
  logic [W-1:0]  dat_q  [NPORTS];
  logic [W-1:0]  dir_q  [NPORTS];
  logic [W-1:0]  mask_q [NPORTS];
  logic [W-1:0]  pin_b  [NPORTS];
  logic [W-1:0]  pol_q  [NEVT];
  logic [W-1:0]  en_q   [NEVT];
  logic [W-1:0]  pend_b [NEVT];
  logic [NE-1:0] pend_all;
  logic [NE-1:0] en_all;
  logic [NPORTS-1:0] dat_we;
  logic [W-1:0]  rd_mux;
  logic [EIW-1:0] eidx;

  evtio_decode #(.NPORTS(NPORTS), .NEVT(NEVT), .AW(AW), .IW(IW)) u_dec (
    .addr (addr),
    .grp  (grp),
    .idx  (idx)
  );

  evtio_sync #(.N(NL)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_s)
  );

  assign eidx = idx[EIW-1:0];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign dat_we[p] = wr_en && (grp == GRP_DATA) && (idx == IW'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        dat_q[p]  <= '0;
        dir_q[p]  <= '0;
        mask_q[p] <= '0;
      end else begin
        if (dat_we[p])
          dat_q[p] <= (dat_q[p] & mask_q[p]) | (wr_data & ~mask_q[p]);
        if (wr_en && (grp == GRP_DIR) && (idx == IW'(p)))
          dir_q[p] <= wr_data;
        if (wr_en && (grp == GRP_MASK) && (idx == IW'(p)))
          mask_q[p] <= wr_data;
      end
    end

    assign pad_out[p*W +: W] = dat_q[p];
    assign pad_oe[p*W +: W]  = dir_q[p];
    assign pin_b[p]          = pin_s[p*W +: W];

    assert_mask_holds_R3: assert property (@(posedge clk) disable iff (rst)
      dat_we[p] |=> ((dat_q[p] & $past(mask_q[p])) == ($past(dat_q[p]) & $past(mask_q[p]))));
  end

  for (genvar e = 0; e < NEVT; e++) begin : g_evt
    logic [W-1:0] clr;

    assign clr = (wr_en && (grp == GRP_PEND) && (idx == IW'(e))) ? wr_data : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        pol_q[e] <= '0;
        en_q[e]  <= '0;
      end else begin
        if (wr_en && (grp == GRP_POL) && (idx == IW'(e)))
          pol_q[e] <= wr_data;
        if (wr_en && (grp == GRP_EN) && (idx == IW'(e)))
          en_q[e] <= wr_data;
      end
    end

    evtio_capture #(.W(W)) u_cap (
      .clk  (clk),
      .rst  (rst),
      .lvl  (pin_s[e*W +: W]),
      .pol  (pol_q[e]),
      .clr  (clr),
      .pend (pend_b[e])
    );

    assign pend_all[e*W +: W] = pend_b[e];
    assign en_all[e*W +: W]   = en_q[e];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend_all & en_all);
  end

  always_comb begin
    rd_mux = '0;
    case (grp)
      GRP_DATA: rd_mux = pin_b[idx];
      GRP_DIR:  rd_mux = dir_q[idx];
      GRP_MASK: rd_mux = mask_q[idx];
      GRP_POL:  rd_mux = pol_q[eidx];
      GRP_EN:   rd_mux = en_q[eidx];
      GRP_PEND: rd_mux = pend_b[eidx];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|en_all));
  assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|pend_all));
  assert_read_latency_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

// File: tb/evtio_ports_bench.sv
module evtio_ports_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [47:0] pad_in = '0;
  logic [47:0] pad_out;
  logic [47:0] pad_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  evtio_ports u_evtio_ports (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [4:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected byte, the monitor compares it
  task automatic host_read(logic [4:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R4 unexpected rd_valid actual=1 expected=0");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 pad_out", pad_out, 48'h0);
    check("R1 pad_oe", pad_oe, 48'h0);
    check("R1 irq", irq, 1'b0);
    host_read(5'd12, 8'h00, "R1 mask0");
    host_read(5'd24, 8'h00, "R1 pend0");

    // R2 latch and direction on port 4
    host_write(5'd4, 8'hA5);
    host_write(5'd10, 8'hFF);
    check("R2 pad_out port4", pad_out[39:32], 8'hA5);
    check("R2 pad_oe port4", pad_oe[39:32], 8'hFF);

    // R3 masked write: mask 0x0F keeps low nibble
    host_write(5'd16, 8'h0F);
    host_write(5'd4, 8'h5A);
    check("R3 masked latch", pad_out[39:32], 8'h55);
    host_read(5'd16, 8'h0F, "R3 mask readback");

    // R4 readback of a driven line: pins follow the latch
    pad_in[39:32] = pad_out[39:32];
    idle(3);
    host_read(5'd4, 8'h55, "R4 readback");

    // R4 synchronizer latency on port 5
    pad_in[47:40] = 8'h81;
    host_read(5'd5, 8'h00, "R4 edge A old");
    host_read(5'd5, 8'h00, "R4 edge B old");
    host_read(5'd5, 8'h81, "R4 edge C new");

    // R10 upper-port activity leaves events untouched
    pad_in[31:24] = 8'hFF;
    idle(4);
    pad_in[31:24] = 8'h00;
    idle(4);
    host_read(5'd24, 8'h00, "R10 pend0");
    host_read(5'd25, 8'h00, "R10 pend1");
    host_read(5'd26, 8'h00, "R10 pend2");
    check("R10 irq", irq, 1'b0);

    // R5 rising event, enable clear
    pad_in[3] = 1'b1;
    idle(4);
    host_read(5'd24, 8'h08, "R5 rising pend");
    check("R9 disabled pending no irq", irq, 1'b0);

    // R9 enabling raises irq
    host_write(5'd21, 8'h08);
    idle(2);
    check("R9 enabled irq", irq, 1'b1);

    // R7 write 0 keeps, write 1 clears
    host_write(5'd24, 8'h00);
    host_read(5'd24, 8'h08, "R7 zero write keeps");
    host_write(5'd24, 8'h08);
    host_read(5'd24, 8'h00, "R7 one write clears");
    idle(1);
    check("R9 irq drops", irq, 1'b0);

    // R6 falling polarity on port 1
    host_write(5'd19, 8'hFF);
    pad_in[8] = 1'b1;
    idle(4);
    host_read(5'd25, 8'h00, "R6 rising ignored");
    pad_in[8] = 1'b0;
    idle(4);
    host_read(5'd25, 8'h01, "R6 falling latched");

    // R8 clear coincident with a new event
    pad_in[8] = 1'b1;
    idle(4);
    pad_in[8] = 1'b0;
    idle(2);
    host_write(5'd25, 8'h01);
    host_read(5'd25, 8'h01, "R8 event beats clear");

    // R9 second port enable
    host_write(5'd23, 8'h40);
    pad_in[22] = 1'b1;
    idle(5);
    check("R9 port2 irq", irq, 1'b1);
    host_read(5'd26, 8'h40, "R5 port2 pend");

    idle(3);
    check("R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule